// File: doc/BRIEF.md
# JTAG Debug Port Transaction Monitor

This block listens, without ever driving anything, to the four signals of a JTAG debug port: test clock, mode select, data in and data out. It keeps its own copy of the 16-state TAP controller and collects the bits shifted through the instruction register and the data register. Each data-register scan that follows an instruction is turned into one decoded transaction record. The record holds the kind of access, the write and read data words, the 2-bit register address, the read/write flag, the 3-bit acknowledge, and flags for a bad acknowledge, set reserved abort bits and a wrong scan length.

All logic runs on a local system clock. The port signals pass through a synchronizer, and a rising test-clock edge is detected in the local domain. The test clock must therefore stay high and low for several system clocks. A record is presented on a valid/ready pair and stays there until it is accepted. A newer record that completes before acceptance replaces the one being held. A single target sits on the chain. Its instruction register is 4 bits wide, and bits of every scan arrive least significant first.

Top module: `jtag_txn_monitor`

## Requirements
- R1: While rst_n is low, rec_valid is 0 and the TAP copy is in Test-Logic-Reset. After reset the decoder is idle: a data-register scan made before any instruction-register scan produces no record.
- R2: The TAP copy follows the standard TMS transitions on each rising test-clock edge. Five consecutive edges with TMS=1 reach Test-Logic-Reset from any state.
- R3: On entry to Update-IR, the low 4 bits of the instruction scan select the record kind. 1110 gives IDCODE (rec_kind 1), 1010 gives DP access (2), 1011 gives AP access (3), 1000 gives ABORT (4) and 1111 gives BYPASS (5). Any other code gives UNKNOWN (6).
- R4: Exactly one record is made, on entry to Update-DR, per instruction scan. Further data-register scans produce no record until the next instruction scan completes.
- R5: For DP and AP access, the scan-in bits give rec_wdata = bits[34:3], rec_addr = bits[2:1] and rec_rnw = bit[0], where 1 means read.
- R6: For DP and AP access, the scan-out bits give rec_rdata = bits[34:3] and rec_ack = bits[2:0]. rec_ack_err is set unless the acknowledge is 010 (OK/FAULT) or 001 (WAIT).
- R7: For ABORT, rec_abort is scan-in bit[0]. rec_rsv_warn is set when any of scan-in bits[31:1] is 1.
- R8: For IDCODE, rec_rdata is scan-out bits[31:0]. For BYPASS and UNKNOWN, rec_wdata is scan-in bits[31:0]. For UNKNOWN, rec_rdata is scan-out bits[31:0].
- R9: rec_len is the number of bits shifted in the data scan. rec_len_err is set when that number differs from 32 (IDCODE), 35 (DP access, AP access, ABORT) or 1 (BYPASS). It is never set for UNKNOWN.
- R10: Once rec_valid is 1, it stays 1 until a cycle with rec_ready high. After that cycle it drops unless a new record is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tck | input | 1 | Observed test clock |
| tms | input | 1 | Observed mode select |
| tdi | input | 1 | Observed scan-in data |
| tdo | input | 1 | Observed scan-out data |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_valid | output | 1 | Record present |
| rec_kind | output | 3 | Access kind code |
| rec_wdata | output | 32 | Data word from scan-in |
| rec_rdata | output | 32 | Data word from scan-out |
| rec_addr | output | 2 | Register address A[3:2] |
| rec_rnw | output | 1 | 1 = read request |
| rec_ack | output | 3 | Acknowledge code |
| rec_abort | output | 1 | Abort request bit |
| rec_ack_err | output | 1 | Acknowledge not a legal code |
| rec_rsv_warn | output | 1 | Reserved abort bits non-zero |
| rec_len_err | output | 1 | Scan length not as expected |
| rec_len | output | 7 | Bits shifted in the data scan |

## Verification
The hardest case to reach from the ports is Test-Logic-Reset entered through TMS alone, with no reset pulse. That path must also avoid both Update states, because passing through either one would itself arm the decoder or emit a record. The stimulus reaches it by leaving Run-Test/Idle with six TMS-high edges through Select-DR and Select-IR. It then runs an ordinary instruction and data scan. A decode that comes out right proves the tracker landed in the correct state. The one-record rule is exercised by a second data scan after an accepted record. That scan must stay silent.

// File: rtl/jtag_mon_pkg.sv
package jtag_mon_pkg;

  typedef enum logic [3:0] {
    TAP_RESET   = 4'h0, TAP_IDLE    = 4'h1,
    TAP_SEL_DR  = 4'h2, TAP_CAP_DR  = 4'h3, TAP_SH_DR  = 4'h4, TAP_EX1_DR = 4'h5,
    TAP_PA_DR   = 4'h6, TAP_EX2_DR  = 4'h7, TAP_UPD_DR = 4'h8,
    TAP_SEL_IR  = 4'h9, TAP_CAP_IR  = 4'hA, TAP_SH_IR  = 4'hB, TAP_EX1_IR = 4'hC,
    TAP_PA_IR   = 4'hD, TAP_EX2_IR  = 4'hE, TAP_UPD_IR = 4'hF
  } tap_state_t;

  typedef enum logic [2:0] {
    KIND_NONE   = 3'd0, KIND_IDCODE = 3'd1, KIND_DPACC  = 3'd2, KIND_APACC = 3'd3,
    KIND_ABORT  = 3'd4, KIND_BYPASS = 3'd5, KIND_UNKNOWN = 3'd6
  } scan_kind_t;

  typedef enum logic {DEC_IDLE = 1'b0, DEC_ARMED = 1'b1} dec_state_t;

  localparam int WORD_W  = 32;
  localparam int ACC_LEN = 35;

  function automatic scan_kind_t kind_of_ir(input logic [3:0] code);
    case (code)
      4'b1110: kind_of_ir = KIND_IDCODE;
      4'b1010: kind_of_ir = KIND_DPACC;
      4'b1011: kind_of_ir = KIND_APACC;
      4'b1000: kind_of_ir = KIND_ABORT;
      4'b1111: kind_of_ir = KIND_BYPASS;
      default: kind_of_ir = KIND_UNKNOWN;
    endcase
  endfunction

  // Zero means no length rule applies.
  function automatic int unsigned len_of_kind(input scan_kind_t k);
    case (k)
      KIND_IDCODE: len_of_kind = WORD_W;
      KIND_DPACC,
      KIND_APACC,
      KIND_ABORT:  len_of_kind = ACC_LEN;
      KIND_BYPASS: len_of_kind = 1;
      default:     len_of_kind = 0;
    endcase
  endfunction

endpackage

// File: rtl/jmon_pin_sync.sv
module jmon_pin_sync #(
  parameter int STAGES = 2,
  parameter int PINS   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pins_in,
  output logic [PINS-1:0] pins_out,
  output logic            clk_rise
);
  logic [PINS-1:0] stage_q [STAGES];
  logic            prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= pins_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign pins_out = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pins_out[0];

  assign clk_rise = pins_out[0] & ~prev_q;
endmodule

// File: rtl/jmon_tap_tracker.sv
module jmon_tap_tracker
  import jtag_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       tms,
  output tap_state_t state_q,
  output tap_state_t state_d
);
  always_comb begin
    case (state_q)
      TAP_RESET:  state_d = tms ? TAP_RESET  : TAP_IDLE;
      TAP_IDLE:   state_d = tms ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_DR: state_d = tms ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR: state_d = tms ? TAP_EX1_DR : TAP_SH_DR;
      TAP_SH_DR:  state_d = tms ? TAP_EX1_DR : TAP_SH_DR;
      TAP_EX1_DR: state_d = tms ? TAP_UPD_DR : TAP_PA_DR;
      TAP_PA_DR:  state_d = tms ? TAP_EX2_DR : TAP_PA_DR;
      TAP_EX2_DR: state_d = tms ? TAP_UPD_DR : TAP_SH_DR;
      TAP_UPD_DR: state_d = tms ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_IR: state_d = tms ? TAP_RESET  : TAP_CAP_IR;
      TAP_CAP_IR: state_d = tms ? TAP_EX1_IR : TAP_SH_IR;
      TAP_SH_IR:  state_d = tms ? TAP_EX1_IR : TAP_SH_IR;
      TAP_EX1_IR: state_d = tms ? TAP_UPD_IR : TAP_PA_IR;
      TAP_PA_IR:  state_d = tms ? TAP_EX2_IR : TAP_PA_IR;
      TAP_EX2_IR: state_d = tms ? TAP_UPD_IR : TAP_SH_IR;
      TAP_UPD_IR: state_d = tms ? TAP_SEL_DR : TAP_IDLE;
      default:    state_d = TAP_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    state_q <= TAP_RESET;
    else if (step) state_q <= state_d;
endmodule

// File: rtl/jmon_shift_capture.sv
module jmon_shift_capture #(
  parameter int MAX_LEN = 35,
  localparam int CNT_W  = $clog2(MAX_LEN + 1) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               clear,
  input  logic               shift,
  input  logic               tdi,
  input  logic               tdo,
  output logic [MAX_LEN-1:0] tdi_bits,
  output logic [MAX_LEN-1:0] tdo_bits,
  output logic [CNT_W-1:0]   count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = count;
    if (clear)                       cnt_d = '0;
    else if (shift && count != CNT_MAX) cnt_d = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    count <= '0;
    else if (step) count <= cnt_d;

  // Bits land at the position given by the running count (first bit = bit 0).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdi_bits <= '0;
      tdo_bits <= '0;
    end else if (step) begin
      if (clear) begin
        tdi_bits <= '0;
        tdo_bits <= '0;
      end else if (shift) begin
        for (int i = 0; i < MAX_LEN; i++) begin
          if (count == CNT_W'(i)) begin
            tdi_bits[i] <= tdi;
            tdo_bits[i] <= tdo;
          end
        end
      end
    end
  end
endmodule

// File: rtl/jmon_scan_decoder.sv
module jmon_scan_decoder
  import jtag_mon_pkg::*;
#(
  parameter int MAX_LEN = 35,
  localparam int CNT_W  = $clog2(MAX_LEN + 1) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ir_done,
  input  logic               dr_done,
  input  logic [MAX_LEN-1:0] tdi_bits,
  input  logic [MAX_LEN-1:0] tdo_bits,
  input  logic [CNT_W-1:0]   count,
  input  logic               rec_ready,
  output logic               rec_valid,
  output scan_kind_t         rec_kind,
  output logic [WORD_W-1:0]  rec_wdata,
  output logic [WORD_W-1:0]  rec_rdata,
  output logic [1:0]         rec_addr,
  output logic               rec_rnw,
  output logic [2:0]         rec_ack,
  output logic               rec_abort,
  output logic               rec_ack_err,
  output logic               rec_rsv_warn,
  output logic               rec_len_err,
  output logic [CNT_W-1:0]   rec_len
);
  dec_state_t  st_q, st_d;
  scan_kind_t  kind_q, kind_d;
  logic        load;
  logic        valid_d;

  scan_kind_t        n_kind;
  logic [WORD_W-1:0] n_wdata, n_rdata;
  logic [1:0]        n_addr;
  logic              n_rnw, n_abort, n_ack_err, n_rsv, n_len_err;
  logic [2:0]        n_ack;
  int unsigned       exp_len;

  // Decode state: armed by an instruction scan, disarmed by one data scan.
  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    if (ir_done) begin
      st_d   = DEC_ARMED;
      kind_d = kind_of_ir(tdi_bits[3:0]);
    end else if (dr_done) begin
      st_d   = DEC_IDLE;
    end
  end

  assign load = dr_done && (st_q == DEC_ARMED);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q   <= DEC_IDLE;
      kind_q <= KIND_NONE;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
    end

  // Field extraction for the record about to be loaded.
  always_comb begin
    n_kind    = kind_q;
    n_wdata   = '0;
    n_rdata   = '0;
    n_addr    = '0;
    n_rnw     = 1'b0;
    n_ack     = '0;
    n_abort   = 1'b0;
    n_ack_err = 1'b0;
    n_rsv     = 1'b0;
    exp_len   = len_of_kind(kind_q);
    case (kind_q)
      KIND_IDCODE: n_rdata = tdo_bits[WORD_W-1:0];
      KIND_DPACC, KIND_APACC: begin
        n_wdata   = tdi_bits[ACC_LEN-1:3];
        n_addr    = tdi_bits[2:1];
        n_rnw     = tdi_bits[0];
        n_rdata   = tdo_bits[ACC_LEN-1:3];
        n_ack     = tdo_bits[2:0];
        n_ack_err = !(tdo_bits[2:0] == 3'b010 || tdo_bits[2:0] == 3'b001);
      end
      KIND_ABORT: begin
        n_wdata = tdi_bits[WORD_W-1:0];
        n_abort = tdi_bits[0];
        n_rsv   = |tdi_bits[WORD_W-1:1];
      end
      KIND_BYPASS: n_wdata = tdi_bits[WORD_W-1:0];
      default: begin
        n_wdata = tdi_bits[WORD_W-1:0];
        n_rdata = tdo_bits[WORD_W-1:0];
      end
    endcase
    n_len_err = (exp_len != 0) && (int'(count) != int'(exp_len));
  end

  always_comb begin
    valid_d = rec_valid;
    if (load)                       valid_d = 1'b1;
    else if (rec_valid && rec_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rec_valid <= 1'b0;
    else        rec_valid <= valid_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rec_kind     <= KIND_NONE;
      rec_wdata    <= '0;
      rec_rdata    <= '0;
      rec_addr     <= '0;
      rec_rnw      <= 1'b0;
      rec_ack      <= '0;
      rec_abort    <= 1'b0;
      rec_ack_err  <= 1'b0;
      rec_rsv_warn <= 1'b0;
      rec_len_err  <= 1'b0;
      rec_len      <= '0;
    end else if (load) begin
      rec_kind     <= n_kind;
      rec_wdata    <= n_wdata;
      rec_rdata    <= n_rdata;
      rec_addr     <= n_addr;
      rec_rnw      <= n_rnw;
      rec_ack      <= n_ack;
      rec_abort    <= n_abort;
      rec_ack_err  <= n_ack_err;
      rec_rsv_warn <= n_rsv;
      rec_len_err  <= n_len_err;
      rec_len      <= count;
    end
endmodule

// File: rtl/jtag_txn_monitor.sv
module jtag_txn_monitor
  import jtag_mon_pkg::*;
#(
  parameter int MAX_LEN     = 35,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tck,
  input  logic                         tms,
  input  logic                         tdi,
  input  logic                         tdo,
  input  logic                         rec_ready,
  output logic                         rec_valid,
  output logic [2:0]                   rec_kind,
  output logic [31:0]                  rec_wdata,
  output logic [31:0]                  rec_rdata,
  output logic [1:0]                   rec_addr,
  output logic                         rec_rnw,
  output logic [2:0]                   rec_ack,
  output logic                         rec_abort,
  output logic                         rec_ack_err,
  output logic                         rec_rsv_warn,
  output logic                         rec_len_err,
  output logic [$clog2(MAX_LEN+1):0]   rec_len
);
  localparam int CNT_W = $clog2(MAX_LEN + 1) + 1;

  logic [3:0]         pins_s;
  logic               tck_rise;
  tap_state_t         tap_q, tap_d;
  logic               cap_clear, shifting, ir_done, dr_done;
  logic [MAX_LEN-1:0] tdi_bits, tdo_bits;
  logic [CNT_W-1:0]   bit_cnt;
  scan_kind_t         kind_out;

  jmon_pin_sync #(.STAGES(SYNC_STAGES), .PINS(4)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins_in  ({tdo, tdi, tms, tck}),
    .pins_out (pins_s),
    .clk_rise (tck_rise)
  );

  jmon_tap_tracker u_tap (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (tck_rise),
    .tms     (pins_s[1]),
    .state_q (tap_q),
    .state_d (tap_d)
  );

  assign cap_clear = (tap_d == TAP_CAP_DR) || (tap_d == TAP_CAP_IR);
  assign shifting  = (tap_q == TAP_SH_DR)  || (tap_q == TAP_SH_IR);
  assign ir_done   = tck_rise && (tap_d == TAP_UPD_IR) && (tap_q != TAP_UPD_IR);
  assign dr_done   = tck_rise && (tap_d == TAP_UPD_DR) && (tap_q != TAP_UPD_DR);

  jmon_shift_capture #(.MAX_LEN(MAX_LEN)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (tck_rise),
    .clear    (cap_clear),
    .shift    (shifting),
    .tdi      (pins_s[2]),
    .tdo      (pins_s[3]),
    .tdi_bits (tdi_bits),
    .tdo_bits (tdo_bits),
    .count    (bit_cnt)
  );

  jmon_scan_decoder #(.MAX_LEN(MAX_LEN)) u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .ir_done      (ir_done),
    .dr_done      (dr_done),
    .tdi_bits     (tdi_bits),
    .tdo_bits     (tdo_bits),
    .count        (bit_cnt),
    .rec_ready    (rec_ready),
    .rec_valid    (rec_valid),
    .rec_kind     (kind_out),
    .rec_wdata    (rec_wdata),
    .rec_rdata    (rec_rdata),
    .rec_addr     (rec_addr),
    .rec_rnw      (rec_rnw),
    .rec_ack      (rec_ack),
    .rec_abort    (rec_abort),
    .rec_ack_err  (rec_ack_err),
    .rec_rsv_warn (rec_rsv_warn),
    .rec_len_err  (rec_len_err),
    .rec_len      (rec_len)
  );

  assign rec_kind = kind_out;
endmodule

// File: rtl/jtag_txn_monitor_checker.sv
module jtag_txn_monitor_checker
  import jtag_mon_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       step,
  input logic       tms_s,
  input tap_state_t tap_state,
  input logic       rec_valid,
  input logic       rec_ready,
  input logic [2:0] rec_kind,
  input logic       rec_ack_err,
  input logic       rec_rsv_warn,
  input logic       rec_len_err
);
  logic [2:0] ones_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ones_q <= '0;
    else if (step) begin
      if (!tms_s)            ones_q <= '0;
      else if (ones_q != 3'd7) ones_q <= ones_q + 3'd1;
    end

  // R2: five TMS-high edges in a row leave the tracker in Test-Logic-Reset
  assert_five_ones_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_q >= 3'd5) |-> (tap_state == TAP_RESET));

  // R10: an unaccepted record stays presented
  assert_hold_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> rec_valid);

  // R6: acknowledge error only on access records
  assert_ack_err_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_ack_err) |-> (rec_kind == 3'd2 || rec_kind == 3'd3));

  // R7: reserved warning only on abort records
  assert_rsv_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_rsv_warn) |-> (rec_kind == 3'd4));

  // R9: no length rule for unknown instructions
  assert_len_unknown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_kind == 3'd6) |-> !rec_len_err);

  // R4: a presented record always carries a decoded kind
  assert_kind_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_kind != 3'd0 && rec_kind != 3'd7));
endmodule

bind jtag_txn_monitor jtag_txn_monitor_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .step         (tck_rise),
  .tms_s        (pins_s[1]),
  .tap_state    (tap_q),
  .rec_valid    (rec_valid),
  .rec_ready    (rec_ready),
  .rec_kind     (rec_kind),
  .rec_ack_err  (rec_ack_err),
  .rec_rsv_warn (rec_rsv_warn),
  .rec_len_err  (rec_len_err)
);

// File: tb/sim_jtag_txn_monitor.sv
module sim_jtag_txn_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_TCK   = 4;

  logic clk, rst_n, tck, tms, tdi, tdo, rec_ready;
  logic rec_valid, rec_rnw, rec_abort, rec_ack_err, rec_rsv_warn, rec_len_err;
  logic [2:0]  rec_kind, rec_ack;
  logic [31:0] rec_wdata, rec_rdata;
  logic [1:0]  rec_addr;
  logic [6:0]  rec_len;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  jtag_txn_monitor u0 (
    .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
    .rec_ready(rec_ready), .rec_valid(rec_valid), .rec_kind(rec_kind),
    .rec_wdata(rec_wdata), .rec_rdata(rec_rdata), .rec_addr(rec_addr),
    .rec_rnw(rec_rnw), .rec_ack(rec_ack), .rec_abort(rec_abort),
    .rec_ack_err(rec_ack_err), .rec_rsv_warn(rec_rsv_warn),
    .rec_len_err(rec_len_err), .rec_len(rec_len)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tclk(input logic m, input logic di, input logic dout);
    @(negedge clk);
    tck = 1'b0; tms = m; tdi = di; tdo = dout;
    repeat (HALF_TCK) @(negedge clk);
    tck = 1'b1;
    repeat (HALF_TCK) @(negedge clk);
  endtask

  task automatic to_idle();
    for (int i = 0; i < 5; i++) tclk(1'b1, 1'b0, 1'b0);
    tclk(1'b0, 1'b0, 1'b0);
  endtask

  task automatic ir_scan(input logic [3:0] code);
    tclk(1'b1, 0, 0); tclk(1'b1, 0, 0); tclk(1'b0, 0, 0); tclk(1'b0, 0, 0);
    for (int i = 0; i < 4; i++) tclk(i == 3, code[i], 1'b0);
    tclk(1'b1, 0, 0); tclk(1'b0, 0, 0);
  endtask

  task automatic dr_scan(input logic [63:0] vi, input logic [63:0] vo, input int len);
    tclk(1'b1, 0, 0); tclk(1'b0, 0, 0); tclk(1'b0, 0, 0);
    for (int i = 0; i < len; i++) tclk(i == len - 1, vi[i], vo[i]);
    tclk(1'b1, 0, 0); tclk(1'b0, 0, 0);
  endtask

  task automatic wait_rec(input string req);
    int n = 0;
    while (!rec_valid && n < 100) begin @(negedge clk); n++; end
    chk({req, " record present"}, 64'(rec_valid), 64'd1);
  endtask

  task automatic accept();
    @(negedge clk); rec_ready = 1'b1;
    @(negedge clk); rec_ready = 1'b0;
    chk("R10 drop after accept", 64'(rec_valid), 64'd0);
  endtask

  task automatic no_rec(input string req);
    repeat (20) @(negedge clk);
    chk({req, " no record"}, 64'(rec_valid), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 valid low after reset", 64'(rec_valid), 64'd0);
    to_idle();
    dr_scan(64'h1234, 64'h0, 32);
    no_rec("R1 scan before IR");
  endtask

  task automatic t_idcode();
    ir_scan(4'b1110);
    dr_scan(64'h0, 64'h3BA0_0477, 32);
    wait_rec("R3");
    chk("R3 kind IDCODE", 64'(rec_kind), 64'd1);
    chk("R8 idcode value", 64'(rec_rdata), 64'h3BA0_0477);
    chk("R9 len ok", 64'(rec_len_err), 64'd0);
    chk("R9 len value", 64'(rec_len), 64'd32);
    repeat (10) @(negedge clk);
    chk("R10 hold while not ready", 64'(rec_valid), 64'd1);
    accept();
    dr_scan(64'h0, 64'h5, 32);
    no_rec("R4 second data scan");
  endtask

  task automatic t_dp_write();
    ir_scan(4'b1010);
    dr_scan((64'hCAFE_F00D << 3) | 64'b010, (64'h1234_5678 << 3) | 64'b010, 35);
    wait_rec("R5");
    chk("R3 kind DP", 64'(rec_kind), 64'd2);
    chk("R5 wdata", 64'(rec_wdata), 64'hCAFE_F00D);
    chk("R5 addr", 64'(rec_addr), 64'd1);
    chk("R5 rnw write", 64'(rec_rnw), 64'd0);
    chk("R6 rdata", 64'(rec_rdata), 64'h1234_5678);
    chk("R6 ack", 64'(rec_ack), 64'b010);
    chk("R6 ack ok", 64'(rec_ack_err), 64'd0);
    chk("R9 len ok", 64'(rec_len_err), 64'd0);
    accept();
  endtask

  task automatic t_ap_read();
    ir_scan(4'b1011);
    dr_scan(64'b111, (64'hDEAD_BEEF << 3) | 64'b001, 35);
    wait_rec("R6");
    chk("R3 kind AP", 64'(rec_kind), 64'd3);
    chk("R5 addr", 64'(rec_addr), 64'd3);
    chk("R5 rnw read", 64'(rec_rnw), 64'd1);
    chk("R6 rdata", 64'(rec_rdata), 64'hDEAD_BEEF);
    chk("R6 wait ack ok", 64'(rec_ack_err), 64'd0);
    accept();
  endtask

  task automatic t_bad_ack();
    ir_scan(4'b1010);
    dr_scan(64'h0, 64'b100, 35);
    wait_rec("R6");
    chk("R6 ack value", 64'(rec_ack), 64'b100);
    chk("R6 ack error", 64'(rec_ack_err), 64'd1);
    accept();
  endtask

  task automatic t_abort();
    ir_scan(4'b1000);
    dr_scan(64'h21, 64'h0, 35);
    wait_rec("R7");
    chk("R3 kind ABORT", 64'(rec_kind), 64'd4);
    chk("R7 abort bit", 64'(rec_abort), 64'd1);
    chk("R7 reserved warn", 64'(rec_rsv_warn), 64'd1);
    accept();
    ir_scan(4'b1000);
    dr_scan(64'h1, 64'h0, 35);
    wait_rec("R7");
    chk("R7 clean no warn", 64'(rec_rsv_warn), 64'd0);
    chk("R7 abort bit clean", 64'(rec_abort), 64'd1);
    accept();
  endtask

  task automatic t_len_mismatch();
    ir_scan(4'b1010);
    dr_scan(64'h0, 64'b010, 34);
    wait_rec("R9");
    chk("R9 len error", 64'(rec_len_err), 64'd1);
    chk("R9 len value", 64'(rec_len), 64'd34);
    accept();
  endtask

  task automatic t_unknown_bypass();
    ir_scan(4'b0101);
    dr_scan(64'hA5, 64'h3C, 8);
    wait_rec("R8");
    chk("R3 kind UNKNOWN", 64'(rec_kind), 64'd6);
    chk("R8 unknown wdata", 64'(rec_wdata), 64'hA5);
    chk("R8 unknown rdata", 64'(rec_rdata), 64'h3C);
    chk("R9 unknown no len err", 64'(rec_len_err), 64'd0);
    accept();
    ir_scan(4'b1111);
    dr_scan(64'h1, 64'h0, 1);
    wait_rec("R8");
    chk("R3 kind BYPASS", 64'(rec_kind), 64'd5);
    chk("R8 bypass bits", 64'(rec_wdata), 64'h1);
    chk("R9 bypass len ok", 64'(rec_len_err), 64'd0);
    accept();
  endtask

  task automatic t_tms_reset();
    for (int i = 0; i < 6; i++) tclk(1'b1, 1'b0, 1'b0);
    tclk(1'b0, 1'b0, 1'b0);
    no_rec("R2 tms path silent");
    ir_scan(4'b1110);
    dr_scan(64'h0, 64'h0000_BEEF, 32);
    wait_rec("R2");
    chk("R2 decode after tms reset", 64'(rec_rdata), 64'h0000_BEEF);
    chk("R2 kind after tms reset", 64'(rec_kind), 64'd1);
    accept();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tck = 1'b0; tms = 1'b1; tdi = 1'b0; tdo = 1'b0; rec_ready = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_idcode();
    t_dp_write();
    t_ap_read();
    t_bad_ack();
    t_abort();
    t_len_mismatch();
    t_unknown_bypass();
    t_tms_reset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule